// File: doc/BRIEF.md
# System Clock Source Controller

This block chooses which oscillator clocks a small microcontroller. Three sources exist: an internal RC oscillator (nominal 24 MHz), an external crystal oscillator and a PLL that doubles its reference. The block does not generate clocks. It decides which source is active and drives the enables and one-hot mux selects that an external glitch-free clock network acts on. It also produces a clock-enable tick for a programmable integer divider on the internal path.

After reset the core always runs from the internal oscillator. A boot strap then starts a power-up sequence. The sequence may start the crystal, qualify it against a software-supplied timeout and, if requested, bring up the PLL from the crystal. The sequence never stalls. A crystal that does not qualify in time raises a sticky failure flag, and the core stays on the internal source with the PLL left off. At run time, software may request a source switch or a PLL enable. A request whose target or reference is not ready is dropped without any indication.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: While rst_ni is low, active_src_o is 00 (internal), src_mux_o is 001, div_code_o is 0, and pll_en_o, ext_en_o, ext_stable_o, ext_fail_o and handover_o are 0.
- R2: The 4-bit divider code selects the internal-path divisor. Codes 0 to 12 map in order to 1, 2, 3, 4, 5, 6, 7, 8, 16, 32, 64, 128 and 256. int_tick_o pulses exactly once every divisor cycles, starting from the cycle after a write.
- R3: Divider codes 13, 14 and 15 behave as divide-by-1: int_tick_o is high every cycle.
- R4: With boot_sel_i = 01, ext_en_o asserts in the first cycle after reset. Once ext_rdy_i has been high for HOLD_CYC consecutive cycles, ext_stable_o sets and the block hands over to the external source (active_src_o = 01, src_mux_o = 010).
- R5: If the crystal is not stable within ext_timeout_i cycles of ext_en_o, ext_fail_o sets and stays set. The block stays on the internal source, and the boot sequence never enables the PLL.
- R6: With boot_sel_i = 10, after the crystal qualifies the block raises pll_en_o with the external reference selected (pll_ref_ext_o = 1). pll_lock_o asserts LOCK_CYC cycles later, and the block then hands over to the PLL (active_src_o = 10, src_mux_o = 100).
- R7: A switch request (sel_wr_i) to a source that is not ready is ignored. The internal source is always ready, the external source is ready when ext_stable_o is 1, and the PLL is ready when pll_lock_o is 1. An ignored request changes neither active_src_o nor handover_o.
- R8: A switch request to a ready source that differs from the active one produces a one-cycle handover_o pulse. active_src_o and src_mux_o take the new value in that same cycle.
- R9: A PLL enable request (pll_wr_i with pll_on_i = 1) is ignored when the selected reference is not ready. The external reference needs ext_stable_o; the internal reference is always ready.
- R10: A PLL disable request is ignored while the PLL is the active source.
- R11: A drop of ext_rdy_i before HOLD_CYC consecutive cycles restarts the stability count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_sel_i | input | 2 | Boot target strap: 00 internal, 01 external, 10 PLL on external reference |
| ext_timeout_i | input | TO_W | Crystal start window in cycles |
| ext_rdy_i | input | 1 | Ready flag from the crystal oscillator model |
| sel_wr_i | input | 1 | Source switch request strobe |
| sel_src_i | input | 2 | Requested source: 00 internal, 01 external, 10 PLL |
| div_wr_i | input | 1 | Divider code write strobe |
| div_code_i | input | 4 | Divider code |
| pll_wr_i | input | 1 | PLL control write strobe |
| pll_on_i | input | 1 | 1 requests PLL enable, 0 requests disable |
| pll_ref_ext_i | input | 1 | PLL reference for an enable: 1 external, 0 internal |
| active_src_o | output | 2 | Active source code |
| src_mux_o | output | 3 | One-hot mux select: bit0 internal, bit1 external, bit2 PLL |
| handover_o | output | 1 | One-cycle source handover strobe |
| div_code_o | output | 4 | Current divider code |
| int_tick_o | output | 1 | Internal-path divided clock enable |
| ext_en_o | output | 1 | Crystal oscillator enable |
| ext_stable_o | output | 1 | Crystal qualified stable |
| ext_fail_o | output | 1 | Sticky crystal start failure |
| pll_en_o | output | 1 | PLL enable |
| pll_ref_ext_o | output | 1 | PLL reference currently selected |
| pll_lock_o | output | 1 | Modelled PLL lock |

## Verification
The assertions assume that ext_rdy_i comes from a model that only reports ready while ext_en_o is high. They also assume that no request pairs a switch to the PLL with a PLL disable in the same cycle. The bench therefore holds ext_rdy_i low, or brings it high only after a settle delay following reset. It issues every request on its own, and it changes boot_sel_i and ext_timeout_i only while reset is asserted.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_PLL = 2'b10
  } src_e;

  localparam int DIV_CNT_W = 8;

  // divisor minus one for a divider code; codes above 12 fall back to /1
  function automatic logic [DIV_CNT_W-1:0] div_m1(input logic [3:0] code);
    logic [DIV_CNT_W-1:0] r;
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3,
      4'd4, 4'd5, 4'd6, 4'd7: r = DIV_CNT_W'(code);
      4'd8:    r = 8'd15;
      4'd9:    r = 8'd31;
      4'd10:   r = 8'd63;
      4'd11:   r = 8'd127;
      4'd12:   r = 8'd255;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ext_osc_qual.sv
module ext_osc_qual #(
  parameter int TO_W     = 16,
  parameter int HOLD_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            rdy_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            stable_o,
  output logic            fail_o
);
  localparam int RUN_W = $clog2(HOLD_CYC + 1);

  logic [TO_W-1:0]  elapsed_q;
  logic [RUN_W-1:0] run_q;
  logic             stable_q, fail_q;
  logic             hold_done;

  assign hold_done = rdy_i && (run_q == RUN_W'(HOLD_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      run_q     <= '0;
      stable_q  <= 1'b0;
      fail_q    <= 1'b0;
    end else if (!en_i) begin
      elapsed_q <= '0;
      run_q     <= '0;
    end else if (!stable_q && !fail_q) begin
      elapsed_q <= elapsed_q + 1'b1;
      run_q     <= rdy_i ? run_q + 1'b1 : '0;
      if (hold_done) stable_q <= 1'b1;
      else if (({1'b0, elapsed_q} + 1'b1) >= {1'b0, timeout_i}) fail_q <= 1'b1;
    end
  end

  assign stable_o = stable_q;
  assign fail_o   = fail_q;

  // R5
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> fail_q);
  // R5
  stable_fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stable_q && fail_q));
  // R11
  stable_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stable_q) |-> $past(rdy_i) && $past(en_i));
endmodule

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
  parameter int LOCK_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic lock_o
);
  localparam int CNT_W = $clog2(LOCK_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      if (cnt_q == CNT_W'(LOCK_CYC - 1)) lock_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lock_o = lock_q;

  // R6
  lock_rise_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(en_i));
endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
  import sysclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);
  logic [DIV_CNT_W-1:0] cnt_q;
  logic [DIV_CNT_W-1:0] lim;

  assign lim    = div_m1(code_i);
  assign tick_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  // R3
  fallback_div1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i > 4'd12) |-> tick_o);
endmodule

// File: rtl/sysclk_src_ctrl.sv
module sysclk_src_ctrl
  import sysclk_pkg::*;
#(
  parameter int TO_W     = 16,
  parameter int HOLD_CYC = 4,
  parameter int LOCK_CYC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      boot_sel_i,
  input  logic [TO_W-1:0] ext_timeout_i,
  input  logic            ext_rdy_i,
  input  logic            sel_wr_i,
  input  logic [1:0]      sel_src_i,
  input  logic            div_wr_i,
  input  logic [3:0]      div_code_i,
  input  logic            pll_wr_i,
  input  logic            pll_on_i,
  input  logic            pll_ref_ext_i,
  output logic [1:0]      active_src_o,
  output logic [2:0]      src_mux_o,
  output logic            handover_o,
  output logic [3:0]      div_code_o,
  output logic            int_tick_o,
  output logic            ext_en_o,
  output logic            ext_stable_o,
  output logic            ext_fail_o,
  output logic            pll_en_o,
  output logic            pll_ref_ext_o,
  output logic            pll_lock_o
);
  typedef enum logic [1:0] {ST_BOOT, ST_EXT_WAIT, ST_PLL_WAIT, ST_RUN} st_e;

  st_e        state_q;
  src_e       active_q;
  logic       handover_q, boot_pll_q;
  logic [3:0] div_q;
  logic       ext_en_q, pll_en_q, pll_ref_q;
  logic       ext_stable, ext_fail, pll_lock;
  logic       tgt_rdy, sel_ok, ref_ok;

  ext_osc_qual #(.TO_W(TO_W), .HOLD_CYC(HOLD_CYC)) u_ext (
    .clk_i, .rst_ni, .en_i(ext_en_q), .rdy_i(ext_rdy_i),
    .timeout_i(ext_timeout_i), .stable_o(ext_stable), .fail_o(ext_fail)
  );

  pll_lock_model #(.LOCK_CYC(LOCK_CYC)) u_pll (
    .clk_i, .rst_ni, .en_i(pll_en_q), .lock_o(pll_lock)
  );

  clk_prescaler u_div (
    .clk_i, .rst_ni, .load_i(div_wr_i), .code_i(div_q), .tick_o(int_tick_o)
  );

  always_comb begin
    case (sel_src_i)
      SRC_INT: tgt_rdy = 1'b1;
      SRC_EXT: tgt_rdy = ext_stable;
      SRC_PLL: tgt_rdy = pll_lock;
      default: tgt_rdy = 1'b0;
    endcase
  end

  assign sel_ok = (state_q == ST_RUN) && sel_wr_i && tgt_rdy && (sel_src_i != active_q);
  assign ref_ok = pll_ref_ext_i ? ext_stable : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BOOT;
      active_q   <= SRC_INT;
      handover_q <= 1'b0;
      boot_pll_q <= 1'b0;
      div_q      <= '0;
      ext_en_q   <= 1'b0;
      pll_en_q   <= 1'b0;
      pll_ref_q  <= 1'b0;
    end else begin
      handover_q <= 1'b0;
      if (div_wr_i) div_q <= div_code_i;
      case (state_q)
        ST_BOOT: begin
          boot_pll_q <= (boot_sel_i == SRC_PLL);
          if (boot_sel_i == SRC_EXT || boot_sel_i == SRC_PLL) begin
            ext_en_q <= 1'b1;
            state_q  <= ST_EXT_WAIT;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_EXT_WAIT: begin
          if (ext_fail) begin
            state_q <= ST_RUN;  // carry on from the internal source
          end else if (ext_stable) begin
            if (boot_pll_q) begin
              pll_en_q  <= 1'b1;
              pll_ref_q <= 1'b1;
              state_q   <= ST_PLL_WAIT;
            end else begin
              active_q   <= SRC_EXT;
              handover_q <= 1'b1;
              state_q    <= ST_RUN;
            end
          end
        end
        ST_PLL_WAIT: begin
          if (pll_lock) begin
            active_q   <= SRC_PLL;
            handover_q <= 1'b1;
            state_q    <= ST_RUN;
          end
        end
        default: begin
          if (sel_ok) begin
            active_q   <= src_e'(sel_src_i);
            handover_q <= 1'b1;
          end
          if (pll_wr_i) begin
            if (pll_on_i) begin
              if (!pll_en_q && ref_ok) begin
                pll_en_q  <= 1'b1;
                pll_ref_q <= pll_ref_ext_i;
              end
            end else if (active_q != SRC_PLL && !(sel_ok && sel_src_i == SRC_PLL)) begin
              pll_en_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    case (active_q)
      SRC_EXT: src_mux_o = 3'b010;
      SRC_PLL: src_mux_o = 3'b100;
      default: src_mux_o = 3'b001;
    endcase
  end

  assign active_src_o  = active_q;
  assign handover_o    = handover_q;
  assign div_code_o    = div_q;
  assign ext_en_o      = ext_en_q;
  assign ext_stable_o  = ext_stable;
  assign ext_fail_o    = ext_fail;
  assign pll_en_o      = pll_en_q;
  assign pll_ref_ext_o = pll_ref_q;
  assign pll_lock_o    = pll_lock;

  // R8
  src_change_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> handover_q);
  // R4
  ext_active_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == SRC_EXT) |-> ext_stable);
  // R7
  pll_active_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == SRC_PLL) |-> pll_lock);
  // R9
  pll_ref_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_q) |-> (!pll_ref_q || ext_stable));
  // R5
  fail_no_ext_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fail |-> !(pll_en_q && pll_ref_q));
  // R10
  pll_keep_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == SRC_PLL) |-> pll_en_q);
endmodule

// File: tb/sim_sysclk_src_ctrl.sv
module sim_sysclk_src_ctrl;
  localparam int TO_W = 16, HOLD_CYC = 4, LOCK_CYC = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] boot_sel = 2'b00;
  logic [TO_W-1:0] ext_timeout = 16'd1000;
  logic ext_rdy = 1'b0, sel_wr = 1'b0, div_wr = 1'b0, pll_wr = 1'b0;
  logic pll_on = 1'b0, pll_ref_ext = 1'b0;
  logic [1:0] sel_src = 2'b00;
  logic [3:0] div_code = 4'd0;
  logic [1:0] active_src;
  logic [2:0] src_mux;
  logic [3:0] div_code_o;
  logic handover, int_tick, ext_en, ext_stable, ext_fail, pll_en, pll_ref_o, pll_lock;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sysclk_src_ctrl #(.TO_W(TO_W), .HOLD_CYC(HOLD_CYC), .LOCK_CYC(LOCK_CYC)) u0 (
    .clk_i(clk), .rst_ni, .boot_sel_i(boot_sel), .ext_timeout_i(ext_timeout),
    .ext_rdy_i(ext_rdy), .sel_wr_i(sel_wr), .sel_src_i(sel_src),
    .div_wr_i(div_wr), .div_code_i(div_code), .pll_wr_i(pll_wr), .pll_on_i(pll_on),
    .pll_ref_ext_i(pll_ref_ext), .active_src_o(active_src), .src_mux_o(src_mux),
    .handover_o(handover), .div_code_o(div_code_o), .int_tick_o(int_tick),
    .ext_en_o(ext_en), .ext_stable_o(ext_stable), .ext_fail_o(ext_fail),
    .pll_en_o(pll_en), .pll_ref_ext_o(pll_ref_o), .pll_lock_o(pll_lock)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] bs, input logic [TO_W-1:0] to, input logic rdy);
    @(negedge clk);
    rst_ni = 1'b0; boot_sel = bs; ext_timeout = to; ext_rdy = 1'b0;
    sel_wr = 0; div_wr = 0; pll_wr = 0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    ext_rdy = rdy;
  endtask

  // R1
  task automatic t_reset;
    @(negedge clk);
    rst_ni = 1'b0; boot_sel = 2'b01;
    cyc(2);
    chk("R1 active", active_src, 0);
    chk("R1 mux", src_mux, 3'b001);
    chk("R1 div", div_code_o, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 ext_en", ext_en, 0);
    chk("R1 flags", {ext_stable, ext_fail, handover}, 0);
  endtask

  // R2 R3
  task automatic t_prescaler;
    int divs[16] = '{1,2,3,4,5,6,7,8,16,32,64,128,256,1,1,1};
    do_reset(2'b00, 16'd1000, 1'b0);
    for (int c = 0; c < 16; c++) begin
      int ticks = 0;
      div_code = 4'(c); div_wr = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
      chk(c > 12 ? "R3 code" : "R2 code", div_code_o, c);
      for (int k = 0; k < 12 * divs[c]; k++) begin
        if (int_tick) ticks++;
        @(negedge clk);
      end
      chk(c > 12 ? "R3 ticks" : "R2 ticks", ticks, 12);
    end
  endtask

  // R4 R11
  task automatic t_boot_ext;
    int ho = 0;
    do_reset(2'b01, 16'd1000, 1'b0);
    chk("R4 ext_en", ext_en, 1);
    ext_rdy = 1'b1;
    cyc(HOLD_CYC - 1);
    ext_rdy = 1'b0;
    cyc(10);
    chk("R11 not stable", ext_stable, 0);
    chk("R11 still int", active_src, 0);
    ext_rdy = 1'b1;
    for (int i = 0; i < 50 && active_src != 2'b01; i++) begin
      @(negedge clk);
      if (handover) ho++;
    end
    chk("R4 active", active_src, 1);
    chk("R4 mux", src_mux, 3'b010);
    chk("R4 stable", ext_stable, 1);
    chk("R4 handover", ho, 1);
    chk("R4 pll off", pll_en, 0);
  endtask

  // R6
  task automatic t_boot_pll;
    int ho = 0;
    do_reset(2'b10, 16'd1000, 1'b1);
    for (int i = 0; i < 100 && active_src != 2'b10; i++) begin
      @(negedge clk);
      if (handover) ho++;
    end
    chk("R6 active", active_src, 2);
    chk("R6 mux", src_mux, 3'b100);
    chk("R6 pll_en/ref/lock", {pll_en, pll_ref_o, pll_lock}, 3'b111);
    chk("R6 handover", ho, 1);
  endtask

  // R5 R7 R8 R9 R10
  task automatic t_fail_and_switch;
    do_reset(2'b10, 16'd20, 1'b0);
    cyc(8);
    chk("R5 no early fail", ext_fail, 0);
    cyc(50);
    chk("R5 fail", ext_fail, 1);
    chk("R5 on int", active_src, 0);
    chk("R5 pll never", pll_en, 0);
    ext_rdy = 1'b1;
    cyc(20);
    chk("R5 sticky", {ext_fail, ext_stable}, 2'b10);
    // switch to unready sources
    sel_src = 2'b01; sel_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0;
    chk("R7 ext ignored", {active_src, handover}, 0);
    sel_src = 2'b10; sel_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0;
    chk("R7 pll ignored", {active_src, handover}, 0);
    // PLL from unready external reference
    pll_on = 1'b1; pll_ref_ext = 1'b1; pll_wr = 1'b1;
    @(negedge clk);
    pll_wr = 1'b0;
    cyc(2);
    chk("R9 ext ref ignored", pll_en, 0);
    pll_ref_ext = 1'b0; pll_wr = 1'b1;
    @(negedge clk);
    pll_wr = 1'b0;
    chk("R9 int ref accepted", {pll_en, pll_ref_o}, 2'b10);
    cyc(LOCK_CYC + 2);
    chk("R9 lock", pll_lock, 1);
    sel_src = 2'b10; sel_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0;
    chk("R8 strobe", handover, 1);
    chk("R8 active", active_src, 2);
    chk("R8 mux", src_mux, 3'b100);
    @(negedge clk);
    chk("R8 one cycle", handover, 0);
    pll_on = 1'b0; pll_wr = 1'b1;
    @(negedge clk);
    pll_wr = 1'b0;
    cyc(2);
    chk("R10 pll kept", {pll_en, pll_lock}, 2'b11);
    sel_src = 2'b00; sel_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0;
    chk("R8 back to int", {handover, src_mux}, 4'b1001);
    pll_wr = 1'b1;
    @(negedge clk);
    pll_wr = 1'b0;
    chk("R10 off when inactive", pll_en, 0);
  endtask

  initial begin
    t_reset();
    t_prescaler();
    t_boot_ext();
    t_boot_pll();
    t_fail_and_switch();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule